// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter

This block is a synchronous binary counter made of identical 4-bit stages. Each stage can take a parallel value, count in either direction, or hold. It also drives an active-low terminal flag. That flag looks ahead: it is low when the stage sits at its last value for the chosen direction and its carry enable is asserted. Stages are chained by feeding each flag into the carry enable of the next stage. The result behaves as one wide synchronous counter and needs no extra gating.

A small mode selector inside each stage names the operation for the coming edge:

- `MODE_CLEAR` is synchronous reset. It has the highest priority.
- `MODE_LOAD` takes the data word.
- `MODE_UP` and `MODE_DOWN` advance the count.
- `MODE_HOLD` keeps the value.

Every transition is taken from whichever mode is selected straight into the mode selected at the next edge; there is no sequencing between modes. Load wins over both enables. Counting needs both active-low enables low. The terminal flag is decoded combinationally from the stored count, the carry enable and the direction. The parallel enable does not affect it.

Top module: `updn_chain`

## Requirements
- R1: A high `rst` at a rising edge sets the count to zero, even when `load_n` is low at the same time.
- R2: With `rst` low and `load_n` low, the count takes `din` at the next rising edge, whatever the levels of `par_en_n` and `car_en_n`.
- R3: With `rst` high-free, `load_n` high, both enables low and `up` high, the count increments by one each edge and wraps from all ones to zero.
- R4: Under the same enables with `up` low, the count decrements by one each edge and wraps from zero to all ones.
- R5: With `load_n` high and either `par_en_n` or `car_en_n` high, the count keeps its value.
- R6: `tc_n` is low exactly when `car_en_n` is low and the count is all ones with `up` high, or all zeros with `up` low. Otherwise it is high, and the level of `par_en_n` does not change it.
- R7: `tc_n` follows a change of `up` or `car_en_n` within the same clock cycle, with no edge needed.
- R8: In a chain, a stage advances only when every lower stage presents its terminal flag. The whole chain therefore counts as one `CNT_W`-bit counter in both directions, including full wrap-around.
- R9: A single 4-bit stage reproduces the sequence 13, 14, 15, 0, 1, 2, 2, 1, 0, 15, 14, 13. The steps are: load 13, count up five times, hold once, count down five times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low parallel load |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| par_en_n | input | 1 | Active-low count enable, parallel to all stages |
| car_en_n | input | 1 | Active-low carry enable into the lowest stage |
| din | input | CNT_W | Parallel load value |
| q | output | CNT_W | Current count |
| tc_n | output | 1 | Active-low terminal flag of the highest stage |

## Verification
The bench builds two copies of the chain from the same controls.

The first uses `STAGES=4` for a 16-bit counter. It shows carries and borrows rippling across nibble boundaries and the full wrap between 0xFFFF and 0x0000.

The second uses `STAGES=1`. It isolates one stage, so the 4-bit reference sequence and the single-stage terminal decode can be seen without carry effects.

Both copies are compared each cycle against behavioural 16-bit and 4-bit integer models.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [2:0] {
        MODE_CLEAR,
        MODE_LOAD,
        MODE_UP,
        MODE_DOWN,
        MODE_HOLD
    } mode_e;
endpackage

// File: rtl/updn_mode_sel.sv
module updn_mode_sel
    import updn_pkg::*;
(
    input  logic  rst,
    input  logic  load_n,
    input  logic  par_en_n,
    input  logic  car_en_n,
    input  logic  up,
    output mode_e mode
);
    // Priority: clear, then load, then count, else hold.
    always_comb begin
        if (rst)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (!par_en_n && !car_en_n)
            mode = up ? MODE_UP : MODE_DOWN;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/updn_term_dec.sv
module updn_term_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         car_en_n,
    input  logic         up,
    output logic         tc_n
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &q;
        at_bottom = ~|q;
        tc_n      = !(!car_en_n && (up ? at_top : at_bottom));
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         par_en_n,
    input  logic         car_en_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc_n
);
    localparam logic [W-1:0] ONE = W'(1);

    mode_e        mode;
    logic [W-1:0] q_next;

    updn_mode_sel u_sel (
        .rst      (rst),
        .load_n   (load_n),
        .par_en_n (par_en_n),
        .car_en_n (car_en_n),
        .up       (up),
        .mode     (mode)
    );

    // Next-state selection per named mode.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_next = '0;
            MODE_LOAD:  q_next = din;
            MODE_UP:    q_next = q + ONE;
            MODE_DOWN:  q_next = q - ONE;
            MODE_HOLD:  q_next = q;
            default:    q_next = q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    // Output decode.
    updn_term_dec #(.W(W)) u_dec (
        .q        (q),
        .car_en_n (car_en_n),
        .up       (up),
        .tc_n     (tc_n)
    );
endmodule

// File: rtl/updn_chain.sv
module updn_chain #(
    parameter int  STAGE_W = 4,
    parameter int  STAGES  = 4,
    localparam int CNT_W   = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             up,
    input  logic             par_en_n,
    input  logic             car_en_n,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] q,
    output logic             tc_n
);
    logic [STAGES:0] carry_n;

    assign carry_n[0] = car_en_n;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .load_n   (load_n),
            .par_en_n (par_en_n),
            .car_en_n (carry_n[i]),
            .up       (up),
            .din      (din[i*STAGE_W +: STAGE_W]),
            .q        (q[i*STAGE_W +: STAGE_W]),
            .tc_n     (carry_n[i+1])
        );
    end

    assign tc_n = carry_n[STAGES];
endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          load_n,
    input logic          up,
    input logic          par_en_n,
    input logic          car_en_n,
    input logic [CW-1:0] din,
    input logic [CW-1:0] q,
    input logic          tc_n
);
    localparam logic [CW-1:0] ONE = CW'(1);

    a_r2_load_takes_din: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> q == $past(din));

    a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && !par_en_n && !car_en_n && up) |=> q == $past(q) + ONE);

    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && !par_en_n && !car_en_n && !up) |=> q == $past(q) - ONE);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && (par_en_n || car_en_n)) |=> $stable(q));

    a_r6_terminal_flag: assert property (@(posedge clk) disable iff (rst)
        tc_n == (car_en_n || (up ? (q != '1) : (q != '0))));
endmodule

bind updn_chain updn_chain_chk #(.CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .up       (up),
    .par_en_n (par_en_n),
    .car_en_n (car_en_n),
    .din      (din),
    .q        (q),
    .tc_n     (tc_n)
);

// File: tb/updn_chain_tb.sv
`timescale 1ns/1ps
module updn_chain_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        load_n = 1;
    logic        up = 1;
    logic        par_en_n = 1;
    logic        car_en_n = 1;
    logic [15:0] din = '0;
    logic [15:0] q16;
    logic [3:0]  q4;
    logic        tc16, tc4;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [15:0] m16;
    logic [3:0]  m4;

    always #2.5 clk = ~clk;

    updn_chain #(.STAGE_W(4), .STAGES(4)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .up(up),
        .par_en_n(par_en_n), .car_en_n(car_en_n),
        .din(din), .q(q16), .tc_n(tc16)
    );

    updn_chain #(.STAGE_W(4), .STAGES(1)) u_dut_nib (
        .clk(clk), .rst(rst), .load_n(load_n), .up(up),
        .par_en_n(par_en_n), .car_en_n(car_en_n),
        .din(din[3:0]), .q(q4), .tc_n(tc4)
    );

    // Behavioural reference models.
    always @(posedge clk) begin
        if (rst) begin
            m16 <= 16'd0;
            m4  <= 4'd0;
        end else if (!load_n) begin
            m16 <= din;
            m4  <= din[3:0];
        end else if (!par_en_n && !car_en_n) begin
            m16 <= up ? 16'((int'(m16) + 1) % 65536) : 16'((int'(m16) + 65535) % 65536);
            m4  <= up ? 4'((int'(m4) + 1) % 16) : 4'((int'(m4) + 15) % 16);
        end
    end

    function automatic logic exp_tc(int val, int maxv);
        if (car_en_n) return 1'b1;
        if (up) return !(val == maxv);
        return !(val == 0);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " q16"}, int'(q16), int'(m16));
        chk({tag, " q4"},  int'(q4),  int'(m4));
        chk({tag, " tc16"}, int'(tc16), int'(exp_tc(int'(m16), 65535)));
        chk({tag, " tc4"},  int'(tc4),  int'(exp_tc(int'(m4), 15)));
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic drive(logic r, logic ld, logic pe, logic ce, logic u, logic [15:0] d);
        rst = r; load_n = ld; par_en_n = pe; car_en_n = ce; up = u; din = d;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ref_seq[12] = '{13, 14, 15, 0, 1, 2, 2, 1, 0, 15, 14, 13};
        int k;

        // R1: clear wins over a simultaneous load
        drive(1, 0, 0, 0, 1, 16'hABCD);
        tick("R1");
        tick("R1");
        chk("R1 cleared", int'(q16), 0);

        // R2 and R9: load 13 with both enables high
        drive(0, 0, 1, 1, 1, 16'd13);
        tick("R2");
        k = 0;
        chk("R9 seq", int'(q4), ref_seq[k]); k++;
        drive(0, 1, 0, 0, 1, 16'd0);
        for (int i = 0; i < 5; i++) begin
            tick("R3");
            chk("R9 seq", int'(q4), ref_seq[k]); k++;
        end
        drive(0, 1, 1, 0, 1, 16'd0);
        tick("R5");
        chk("R9 seq", int'(q4), ref_seq[k]); k++;
        drive(0, 1, 0, 0, 0, 16'd0);
        for (int i = 0; i < 5; i++) begin
            tick("R4");
            chk("R9 seq", int'(q4), ref_seq[k]); k++;
        end

        // R5: hold via carry enable alone
        drive(0, 1, 0, 1, 1, 16'd0);
        tick("R5");
        tick("R5");

        // R8: chained wrap upward
        drive(0, 0, 0, 0, 1, 16'hFFFD);
        tick("R2");
        drive(0, 1, 0, 0, 1, 16'd0);
        for (int i = 0; i < 6; i++) tick("R8 up wrap");
        chk("R8 after wrap", int'(q16), 16'h0003);

        // R8: chained wrap downward
        drive(0, 0, 0, 0, 0, 16'h0002);
        tick("R2");
        drive(0, 1, 0, 0, 0, 16'd0);
        for (int i = 0; i < 6; i++) tick("R8 down wrap");
        chk("R8 after borrow", int'(q16), 16'hFFFC);

        // R8: carry across a nibble and a borrow across two
        drive(0, 0, 0, 0, 1, 16'h00FE);
        tick("R2");
        drive(0, 1, 0, 0, 1, 16'd0);
        for (int i = 0; i < 4; i++) tick("R8 carry");
        drive(0, 0, 0, 0, 0, 16'h0F01);
        tick("R2");
        drive(0, 1, 0, 0, 0, 16'd0);
        for (int i = 0; i < 3; i++) tick("R8 borrow");

        // R6: terminal flag ignores par_en_n
        drive(0, 0, 1, 1, 1, 16'hFFFF);
        tick("R2");
        drive(0, 1, 1, 0, 1, 16'd0);
        #1;
        chk("R6 tc16 with par_en_n high", int'(tc16), 0);
        chk("R6 tc4 with par_en_n high", int'(tc4), 0);
        tick("R6");

        // R7: flag follows up and car_en_n mid-cycle
        up = 0;
        #1;
        chk("R7 tc16 after dir change", int'(tc16), 1);
        up = 1;
        #0.5;
        chk("R7 tc16 after dir restore", int'(tc16), 0);
        car_en_n = 1;
        #0.5;
        chk("R7 tc4 after carry enable off", int'(tc4), 1);
        tick("R7");

        // R7: zero in down mode
        drive(0, 0, 1, 1, 0, 16'h0000);
        tick("R2");
        car_en_n = 0;
        #1;
        chk("R7 tc16 at zero down", int'(tc16), 0);
        tick("R6");

        // Mixed traffic compared to the models
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[31:28] == 0, r[27:24] != 0, r[23:22] == 3, r[21:20] == 3,
                  r[19], r[15:0]);
            tick("R3 R4 R5 mixed");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule